// File: doc/BRIEF.md
# Clock-Ready Interrupt Register

This block is one 32-bit memory-mapped word that gathers "clock is stable" events from seven clock sources (two internal RC oscillators, two crystal oscillators and three PLLs), plus a failure event from the clock monitor that watches the high-speed crystal. Each event sets a sticky flag. Software chooses which stable flags may raise the interrupt through per-source enable bits, and it acknowledges a flag by writing 1 to its clear bit. All three kinds of field share the one word, each in its own fixed bit range.

Event inputs arrive as single-cycle pulses that are already synchronised to the register clock. The bus side is a plain register port: a write strobe, four byte-lane strobes and write data, with the read data always showing the current word. One interrupt output is raised when any enabled stable flag is set, or whenever the clock-monitor flag is set. The monitor flag has no enable and cannot be masked.

Source order, used by the flag, enable and clear fields alike: index 0 = 40 kHz internal RC, 1 = low-speed crystal, 2 = 8 MHz internal RC, 3 = high-speed crystal, 4 = main PLL, 5 = PLL1, 6 = PLL2.

Top module: `clkrdy_irq_reg`

## Requirements
- R1: After reset the word reads 0x00000000 and `irq_o` is 0.
- R2: A pulse on `stab_evt_i[i]` sets read bit i (bits 0..6, in the source order above) on the next clock edge. The bit stays set until it is cleared.
- R3: A pulse on `mon_fail_i` sets read bit 7 on the next clock edge. The bit stays set until it is cleared.
- R4: Bits 8..14 are the interrupt enables for sources 0..6. They are loaded from `wr_data_i[14:8]` when `wr_en_i` and `wr_strb_i[1]` are both 1, and they read back as written.
- R5: Writing 1 to bit 16+i (i = 0..6) with `wr_strb_i[2]` set clears stable flag i, and writing 1 to bit 23 clears the monitor flag. Writing 0 to any of these bits changes nothing.
- R6: Bits 15 and 16..31 always read 0, including the clear bits just after they are written with 1.
- R7: When a set pulse and a clear write reach the same flag in the same cycle, the flag is set after that edge.
- R8: Writes to bits 0..7 (byte lane 0) do not change any flag.
- R9: A byte lane whose strobe is 0 is not written. With `wr_strb_i[1]` = 0 the enables keep their value, and with `wr_strb_i[2]` = 0 no flag is cleared.
- R10: `irq_o` is 1 exactly when some stable flag i and its enable i are both 1, or the monitor flag is 1.
- R11: The monitor flag drives `irq_o` high even when all enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the word |
| wr_strb_i | input | 4 | Byte-lane write enables, bit n covers data bits 8n+7..8n |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Current register value |
| stab_evt_i | input | 7 | Single-cycle stable pulses, one per source in source order |
| mon_fail_i | input | 1 | Single-cycle clock-monitor failure pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sends a set pulse and a clear write to the same flag in one cycle. A design where the clear wins would read that flag back as 0. It writes all-ones data with only lane 0, only lane 3, or no strobe asserted. A design that ignores the strobes would clear flags or rewrite the enables, and one that lets lane 0 through would disturb the flag bits. It raises the monitor flag while every enable is 0, and it writes 1s into the clear field. A design that masks the monitor flag would leave `irq_o` low, and one that stores the clear bits would read back nonzero upper bits. Each source is set and cleared on its own, which catches swapped source indices and clear bits aimed at the wrong flag.

// File: rtl/clkrdy_pkg.sv
package clkrdy_pkg;
    localparam int WORD_W      = 32;
    localparam int LANE_W      = 8;
    localparam int LANE_CNT    = WORD_W / LANE_W;
    localparam int SRC_CNT     = 7;
    localparam int FLAG_LSB    = 0;
    localparam int MON_BIT     = FLAG_LSB + SRC_CNT;
    localparam int IEN_LSB     = 8;
    localparam int CLR_LSB     = 16;
    localparam int MON_CLR_BIT = CLR_LSB + SRC_CNT;
    localparam int IEN_LANE    = IEN_LSB / LANE_W;
    localparam int CLR_LANE    = CLR_LSB / LANE_W;

    typedef enum logic [2:0] {
        SRC_RC40K  = 3'd0,
        SRC_LSXTAL = 3'd1,
        SRC_RC8M   = 3'd2,
        SRC_HSXTAL = 3'd3,
        SRC_PLL0   = 3'd4,
        SRC_PLL1   = 3'd5,
        SRC_PLL2   = 3'd6
    } src_idx_e;
endpackage

// File: rtl/clkrdy_flag_cell.sv
module clkrdy_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    // A set pulse takes priority over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_i)
            flag_q <= 1'b1;
        else if (clr_i)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q);
    p_clear_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_q);
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(flag_q));
endmodule

// File: rtl/clkrdy_ien_reg.sv
module clkrdy_ien_reg #(
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] ien_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ien_q <= '0;
        else if (we_i)
            ien_q <= d_i;
    end

    assign q_o = ien_q;

    p_ien_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (ien_q == $past(d_i)));
    p_ien_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(ien_q));
endmodule

// File: rtl/clkrdy_irq_merge.sv
module clkrdy_irq_merge #(
    parameter int N = 7
) (
    input  logic [N-1:0] flag_i,
    input  logic [N-1:0] ien_i,
    input  logic         mon_i,
    output logic         irq_o
);
    logic [N-1:0] hit;

    always_comb begin
        for (int k = 0; k < N; k++)
            hit[k] = flag_i[k] & ien_i[k];
        irq_o = (|hit) | mon_i;
    end
endmodule

// File: rtl/clkrdy_irq_reg.sv
module clkrdy_irq_reg
    import clkrdy_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [LANE_CNT-1:0] wr_strb_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic [WORD_W-1:0] rd_data_o,
    input  logic [SRC_CNT-1:0] stab_evt_i,
    input  logic              mon_fail_i,
    output logic              irq_o
);
    logic               ien_we;
    logic               clr_lane_we;
    logic [SRC_CNT-1:0] clr_req;
    logic               mon_clr_req;
    logic [SRC_CNT-1:0] flags;
    logic [SRC_CNT-1:0] ien;
    logic               mon_flag;
    logic               wr_unused;

    // Lane decode: only the enable lane and the clear lane are writable
    assign ien_we      = wr_en_i & wr_strb_i[IEN_LANE];
    assign clr_lane_we = wr_en_i & wr_strb_i[CLR_LANE];
    assign clr_req     = clr_lane_we ? wr_data_i[CLR_LSB +: SRC_CNT] : '0;
    assign mon_clr_req = clr_lane_we & wr_data_i[MON_CLR_BIT];

    // Bits that no write reaches
    assign wr_unused = ^{wr_data_i[IEN_LSB-1:0], wr_data_i[IEN_LSB+SRC_CNT],
                         wr_data_i[WORD_W-1:MON_CLR_BIT+1],
                         wr_strb_i[0], wr_strb_i[LANE_CNT-1]};

    for (genvar g = 0; g < SRC_CNT; g++) begin : g_src
        clkrdy_flag_cell u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (stab_evt_i[g]),
            .clr_i  (clr_req[g]),
            .flag_o (flags[g])
        );
    end

    clkrdy_flag_cell u_mon (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (mon_fail_i),
        .clr_i  (mon_clr_req),
        .flag_o (mon_flag)
    );

    clkrdy_ien_reg #(.WIDTH(SRC_CNT)) u_ien (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (ien_we),
        .d_i   (wr_data_i[IEN_LSB +: SRC_CNT]),
        .q_o   (ien)
    );

    clkrdy_irq_merge #(.N(SRC_CNT)) u_merge (
        .flag_i (flags),
        .ien_i  (ien),
        .mon_i  (mon_flag),
        .irq_o  (irq_o)
    );

    always_comb begin
        rd_data_o = '0;
        rd_data_o[FLAG_LSB +: SRC_CNT] = flags;
        rd_data_o[MON_BIT]             = mon_flag;
        rd_data_o[IEN_LSB +: SRC_CNT]  = ien;
    end

    p_mon_unmasked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mon_fail_i |=> irq_o);
    p_lane0_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stab_evt_i == '0 && !mon_fail_i && !clr_lane_we)
            |=> $stable(rd_data_o[MON_BIT:FLAG_LSB]));
    p_quiet_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o[MON_BIT:FLAG_LSB] == '0) |-> !irq_o);
    p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_lane_we |=> (rd_data_o[WORD_W-1:CLR_LSB] == '0));
endmodule

// File: tb/tb_clkrdy_irq_reg.sv
module tb_clkrdy_irq_reg;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 5000;

    typedef struct {
        logic [31:0] rd;
        logic        irq;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_strb = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [6:0]  stab_evt = '0;
    logic        mon_fail = 1'b0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;
    exp_t sb[$];

    logic [7:0] m_flags = '0;
    logic [6:0] m_ien   = '0;

    clkrdy_irq_reg dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_strb_i  (wr_strb),
        .wr_data_i  (wr_data),
        .rd_data_o  (rd_data),
        .stab_evt_i (stab_evt),
        .mon_fail_i (mon_fail),
        .irq_o      (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus, update model, push the expectation
    task automatic step(input logic [6:0] evt, input logic mon, input logic we,
                        input logic [3:0] strb, input logic [31:0] data, input string tag);
        logic [7:0] clr;
        exp_t e;
        @(negedge clk);
        stab_evt = evt; mon_fail = mon; wr_en = we; wr_strb = strb; wr_data = data;
        clr = (we && strb[2]) ? data[23:16] : 8'h00;
        m_flags = (m_flags & ~clr) | {mon, evt};
        if (we && strb[1]) m_ien = data[14:8];
        e.rd  = {16'h0000, 1'b0, m_ien, m_flags};
        e.irq = (|(m_flags[6:0] & m_ien)) | m_flags[7];
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(7'h00, 1'b0, 1'b0, 4'h0, 32'h0, tag);
    endtask

    // Monitor: compare after each edge that consumed a pushed item
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " rd"}, rd_data, e.rd);
                check({e.tag, " irq"}, {31'b0, irq}, {31'b0, e.irq});
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG && !done) begin
                errors++; checks++;
                $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset rd", rd_data, 32'h0);
        check("R1 reset irq", {31'b0, irq}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 / R5: each source set then cleared on its own
        for (int i = 0; i < 7; i++) begin
            step(7'(1 << i), 1'b0, 1'b0, 4'h0, 32'h0, "R2 set");
            idle("R2 sticky");
            step(7'h00, 1'b0, 1'b1, 4'b0100, 32'(1) << (16 + i), "R5 clear");
        end

        // R3 / R11: monitor flag, no enables
        step(7'h00, 1'b1, 1'b0, 4'h0, 32'h0, "R3 R11 mon set");
        idle("R11 irq unmasked");
        step(7'h00, 1'b0, 1'b1, 4'b0100, 32'h0000_0000, "R5 zero clear no effect");
        step(7'h00, 1'b0, 1'b1, 4'b0100, 32'h0080_0000, "R5 mon clear");

        // R4: enables
        step(7'h00, 1'b0, 1'b1, 4'b0010, 32'h0000_5500, "R4 ien write");
        step(7'h00, 1'b0, 1'b1, 4'b0010, 32'h0000_7F00, "R4 ien all");

        // R10: enabled flag raises irq, masked one does not
        step(7'h01, 1'b0, 1'b0, 4'h0, 32'h0, "R10 enabled flag");
        step(7'h00, 1'b0, 1'b1, 4'b0010, 32'h0000_7E00, "R10 mask source0");
        step(7'h40, 1'b0, 1'b0, 4'h0, 32'h0, "R10 source6");

        // R8 / R9: writes through lanes that must not touch state
        step(7'h00, 1'b0, 1'b1, 4'b0001, 32'hFFFF_FFFF, "R8 lane0 ignored");
        step(7'h00, 1'b0, 1'b1, 4'b1000, 32'hFFFF_FFFF, "R9 lane3 only");
        step(7'h00, 1'b0, 1'b1, 4'b0000, 32'hFFFF_FFFF, "R9 no strobe");
        step(7'h00, 1'b0, 1'b0, 4'b1111, 32'hFFFF_FFFF, "R9 no write enable");

        // R7: set and clear on the same edge
        step(7'h01, 1'b1, 1'b1, 4'b0100, 32'h00FF_0000, "R7 set wins");
        idle("R7 still set");

        // R6: full write of all ones; clear field and reserved bits read 0
        step(7'h00, 1'b0, 1'b1, 4'b1111, 32'hFFFF_FFFF, "R6 upper bits zero");
        step(7'h00, 1'b0, 1'b1, 4'b0010, 32'h0000_0000, "R10 all masked");
        idle("R10 quiet");

        while (sb.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule